// File: doc/BRIEF.md
# Sectored Data Cache with Wrapped Critical-Word Refill

This block is a small direct-mapped data cache. Each line holds one address tag, and the line is divided into subblocks. Every subblock keeps its own valid flag and its own modified flag. A miss fetches only the subblock that holds the requested word, so a partly used line never pulls the whole line over the memory port. When the tag of a line changes, the subblocks that were modified go back to memory, and the clean ones do not.

The memory returns the refill beats starting at the word that the processor asked for and then wraps around the subblock. The stalled access is answered as soon as that first beat lands, while the rest of the subblock is still arriving. While that fill runs, the processor may already hit in other valid subblocks, or in words of the filling subblock that have already arrived. A request for a word of the filling subblock that has not arrived yet waits.

Addresses count words. From the top bit down the address is split into tag, line index, subblock number and word offset. The processor port carries one request at a time with a valid/ready handshake. The response is a one-cycle pulse.

Top module: `sectored_cwf_cache`

## Requirements
- R1: A read that hits a valid subblock with a matching tag is accepted while req_ready is high, and the stored word appears on rsp_rdata with rsp_valid exactly one cycle after acceptance, without any memory command.
- R2: A read or write miss issues exactly one memory read command, whose address is the requested word address itself. The command holds its address and direction until mem_cmd_ready.
- R3: Refill beat k (k = 0 .. WORDS-1) is stored at word offset (requested offset + k) mod WORDS of the missing subblock. Other subblocks are not fetched.
- R4: The missed access is answered in the cycle after the first refill beat is taken, while the remaining beats of that subblock are still outstanding.
- R5: A write hit updates the addressed word and marks its subblock modified, with no memory traffic. A later read returns the new value.
- R6: A miss whose tag differs from the line's tag first writes back every word of each modified subblock of the old line, using the old tag, one write command per word. Clean subblocks are not written. It then installs the new tag with all subblock valid flags cleared, so other subblocks of the new line miss.
- R7: During a refill, a request to a word of the filling subblock that has not arrived is held off (req_ready low) until that word's beat is stored. A request to a word that has already arrived, or to another valid subblock, is accepted.
- R8: From acceptance of a miss until its first refill beat, req_ready stays low, so at most one request is outstanding.
- R9: A write miss fetches the subblock, stores the write data in place of the fetched critical word, and marks the subblock modified.
- R10: After reset every subblock is invalid and clean, req_ready is high, and neither rsp_valid nor mem_cmd_valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address {tag, index, subblock, word} |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data, or echoed write data for writes |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_we | output | 1 | 1 = one-word writeback, 0 = subblock read |
| mem_cmd_addr | output | ADDR_W | Word address (for reads, the critical word) |
| mem_cmd_wdata | output | DATA_W | Writeback data |
| mem_rvalid | input | 1 | Refill beat present |
| mem_rdata | input | DATA_W | Refill beat data |

## Verification
During a refill, the storage of a beat and a hit served from a different subblock of the same line can fall in the same cycle, since both write or read the word array at once. The bench provokes this with back-to-back beats: it issues a hit to another subblock of the filling line right after the critical response. It judges the result by the hit data, and by reading back every word of the freshly filled subblock once the refill ends. A second overlap comes from spaced beats: a request to a not-yet-arrived word of the filling subblock must stall and then return the memory value, while a request to the critical word goes through at once.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_CMD  = 2'd2,
      ST_FILL = 2'd3
   } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
   parameter int LINES = 8,
   parameter int SUBS  = 4,
   parameter int TAG_W = 5,
   localparam int IB   = $clog2(LINES),
   localparam int SB   = $clog2(SUBS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IB-1:0]    a_idx,
   output logic [TAG_W-1:0] a_tag,
   output logic [SUBS-1:0]  a_vld,
   output logic [SUBS-1:0]  a_drt,
   input  logic [IB-1:0]    b_idx,
   output logic [TAG_W-1:0] b_tag,
   output logic [SUBS-1:0]  b_drt,
   input  logic             inst_en,
   input  logic [IB-1:0]    inst_idx,
   input  logic [TAG_W-1:0] inst_tag,
   input  logic             sv_en,
   input  logic [IB-1:0]    sv_idx,
   input  logic [SB-1:0]    sv_sub,
   input  logic             sd0_en,
   input  logic [IB-1:0]    sd0_idx,
   input  logic [SB-1:0]    sd0_sub,
   input  logic             sd1_en,
   input  logic [IB-1:0]    sd1_idx,
   input  logic [SB-1:0]    sd1_sub
);
   logic [TAG_W-1:0] tag_q [LINES];
   logic [SUBS-1:0]  vld_q [LINES];
   logic [SUBS-1:0]  drt_q [LINES];

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [SUBS-1:0] set_v, set_d;
      always_comb begin
         set_v = '0;
         set_d = '0;
         if (sv_en  && sv_idx  == IB'(l)) set_v[sv_sub]  = 1'b1;
         if (sd0_en && sd0_idx == IB'(l)) set_d[sd0_sub] = 1'b1;
         if (sd1_en && sd1_idx == IB'(l)) set_d[sd1_sub] = 1'b1;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q[l] <= '0;
            vld_q[l] <= '0;
            drt_q[l] <= '0;
         end else if (inst_en && inst_idx == IB'(l)) begin
            tag_q[l] <= inst_tag;
            vld_q[l] <= '0;
            drt_q[l] <= '0;
         end else begin
            vld_q[l] <= vld_q[l] | set_v;
            drt_q[l] <= drt_q[l] | set_d;
         end
      end
   end

   assign a_tag = tag_q[a_idx];
   assign a_vld = vld_q[a_idx];
   assign a_drt = drt_q[a_idx];
   assign b_tag = tag_q[b_idx];
   assign b_drt = drt_q[b_idx];

   // install never coincides with flag updates of the same line
   assert_install_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inst_en |-> !(sv_en && sv_idx == inst_idx) && !(sd1_en && sd1_idx == inst_idx));
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
   parameter int DEPTH  = 128,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wa_en,
   input  logic [AW-1:0]     wa_addr,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [AW-1:0]     wb_addr,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [AW-1:0]     ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [AW-1:0]     rb_addr,
   output logic [DATA_W-1:0] rb_data
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wa_en) mem_q[wa_addr] <= wa_data;
      if (wb_en) mem_q[wb_addr] <= wb_data;
   end

   assign ra_data = mem_q[ra_addr];
   assign rb_data = mem_q[rb_addr];

   // processor write and refill beat never target the same word
   assert_no_port_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_en && wb_en) |-> (wa_addr != wb_addr));
endmodule

// File: rtl/sc_refill_seq.sv
module sc_refill_seq #(
   parameter int WORDS = 4,
   localparam int WB   = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WB-1:0]    crit,
   input  logic             beat,
   output logic [WB-1:0]    off,
   output logic             first,
   output logic             last,
   output logic [WORDS-1:0] mask
);
   logic [WB:0]    cnt_q;
   logic [WB-1:0]  crit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         crit_q <= '0;
         mask   <= '0;
      end else if (start) begin
         cnt_q  <= '0;
         crit_q <= crit;
         mask   <= '0;
      end else if (beat) begin
         cnt_q     <= cnt_q + 1'b1;
         mask[off] <= 1'b1;
      end
   end

   assign off   = crit_q + cnt_q[WB-1:0];
   assign first = (cnt_q == '0);
   assign last  = (cnt_q == (WB+1)'(WORDS-1));

   assert_mask_tracks_beats_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mask) == int'(cnt_q));
endmodule

// File: rtl/sectored_cwf_cache.sv
module sectored_cwf_cache
   import sc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int LINES      = 8,
   parameter int SUBS       = 4,
   parameter int WORDS      = 4,
   parameter bit ECHO_WRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_cmd_valid,
   input  logic              mem_cmd_ready,
   output logic              mem_cmd_we,
   output logic [ADDR_W-1:0] mem_cmd_addr,
   output logic [DATA_W-1:0] mem_cmd_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int WB_B   = $clog2(WORDS);
   localparam int SB_B   = $clog2(SUBS);
   localparam int IB     = $clog2(LINES);
   localparam int OFF_B  = SB_B + WB_B;
   localparam int TAG_W  = ADDR_W - IB - OFF_B;
   localparam int SLOT_B = IB + OFF_B;

   if (WORDS < 2 || (1 << WB_B) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (SUBS < 2 || (1 << SB_B) != SUBS) begin : g_bad_subs
      $error("SUBS must be a power of two of at least 2");
   end
   if (LINES < 2 || (1 << IB) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen geometry");
   end

   sc_state_e st;
   logic [TAG_W-1:0] r_tag, p_tag, a_tag, b_tag;
   logic [IB-1:0]    r_idx, p_idx;
   logic [SB_B-1:0]  r_sub, p_sub, wb_sub;
   logic [WB_B-1:0]  r_word, p_word, f_off;
   logic [ADDR_W-1:0] p_addr;
   logic [DATA_W-1:0] p_wdata, ra_data, rb_data, fill_data;
   logic [DATA_W-1:0] cpu_wr_rsp, fill_wr_rsp;
   logic              p_we;
   logic [SUBS-1:0]   a_vld, a_drt, b_drt;
   logic [WORDS-1:0]  fmask;
   logic [OFF_B-1:0]  wb_ptr;
   logic sub_hit, filling, acc, acc_hit, acc_miss, evict, need_wb;
   logic wb_dirty, wb_step, wb_last, beat, f_first, f_last, inst_en;

   assign {r_tag, r_idx, r_sub, r_word} = req_addr;
   assign {p_tag, p_idx, p_sub, p_word} = p_addr;
   assign wb_sub = wb_ptr[OFF_B-1:WB_B];

   if (ECHO_WRITE) begin : g_echo
      assign cpu_wr_rsp  = req_wdata;
      assign fill_wr_rsp = p_wdata;
   end else begin : g_zero
      assign cpu_wr_rsp  = '0;
      assign fill_wr_rsp = '0;
   end

   always_comb begin
      sub_hit = (a_tag == r_tag) && a_vld[r_sub];
      filling = (r_idx == p_idx) && (r_tag == p_tag) && (r_sub == p_sub);
      unique case (st)
         ST_IDLE: req_ready = 1'b1;
         ST_FILL: req_ready = (|fmask) && (filling ? fmask[r_word] : sub_hit);
         default: req_ready = 1'b0;
      endcase
   end

   assign acc      = req_valid && req_ready;
   assign acc_hit  = acc && ((st == ST_FILL) || sub_hit);
   assign acc_miss = acc && (st == ST_IDLE) && !sub_hit;
   assign evict    = (a_tag != r_tag);
   assign need_wb  = evict && (|a_drt);
   assign wb_dirty = b_drt[wb_sub];
   assign wb_step  = (st == ST_WB) && (!wb_dirty || mem_cmd_ready);
   assign wb_last  = (wb_ptr == '1);
   assign beat     = (st == ST_FILL) && mem_rvalid;
   assign inst_en  = (acc_miss && evict && !need_wb) || (wb_step && wb_last);
   assign fill_data = (f_first && p_we) ? p_wdata : mem_rdata;

   assign mem_cmd_valid = ((st == ST_WB) && wb_dirty) || (st == ST_CMD);
   assign mem_cmd_we    = (st == ST_WB);
   assign mem_cmd_addr  = (st == ST_WB) ? {b_tag, p_idx, wb_ptr} : p_addr;
   assign mem_cmd_wdata = rb_data;

   sc_tag_store #(.LINES(LINES), .SUBS(SUBS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .a_idx(r_idx), .a_tag(a_tag), .a_vld(a_vld), .a_drt(a_drt),
      .b_idx(p_idx), .b_tag(b_tag), .b_drt(b_drt),
      .inst_en(inst_en), .inst_idx(acc_miss ? r_idx : p_idx),
      .inst_tag(acc_miss ? r_tag : p_tag),
      .sv_en(beat && f_last), .sv_idx(p_idx), .sv_sub(p_sub),
      .sd0_en(acc_hit && req_we), .sd0_idx(r_idx), .sd0_sub(r_sub),
      .sd1_en(beat && f_first && p_we), .sd1_idx(p_idx), .sd1_sub(p_sub)
   );

   sc_data_store #(.DEPTH(1 << SLOT_B), .DATA_W(DATA_W)) u_data (
      .clk(clk), .rst_n(rst_n),
      .wa_en(acc_hit && req_we), .wa_addr({r_idx, r_sub, r_word}), .wa_data(req_wdata),
      .wb_en(beat), .wb_addr({p_idx, p_sub, f_off}), .wb_data(fill_data),
      .ra_addr({r_idx, r_sub, r_word}), .ra_data(ra_data),
      .rb_addr({p_idx, wb_ptr}), .rb_data(rb_data)
   );

   sc_refill_seq #(.WORDS(WORDS)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start((st == ST_CMD) && mem_cmd_ready), .crit(p_word), .beat(beat),
      .off(f_off), .first(f_first), .last(f_last), .mask(fmask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         p_addr    <= '0;
         p_we      <= 1'b0;
         p_wdata   <= '0;
         wb_ptr    <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc_hit || (beat && f_first);
         if (acc_hit)
            rsp_rdata <= req_we ? cpu_wr_rsp : ra_data;
         else if (beat && f_first)
            rsp_rdata <= p_we ? fill_wr_rsp : mem_rdata;
         unique case (st)
            ST_IDLE: if (acc_miss) begin
               p_addr  <= req_addr;
               p_we    <= req_we;
               p_wdata <= req_wdata;
               wb_ptr  <= '0;
               st      <= need_wb ? ST_WB : ST_CMD;
            end
            ST_WB: if (wb_step) begin
               wb_ptr <= wb_ptr + 1'b1;
               if (wb_last) st <= ST_CMD;
            end
            ST_CMD:  if (mem_cmd_ready) st <= ST_FILL;
            ST_FILL: if (beat && f_last) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_busy_blocks_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WB || st == ST_CMD) |-> !req_ready);
   assert_cmd_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && !mem_cmd_ready) |=>
         mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_we));
   assert_wb_old_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && mem_cmd_we) |-> (mem_cmd_addr[ADDR_W-1 -: TAG_W] != p_tag));
   assert_early_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && f_first) |=> rsp_valid && (st == ST_FILL));
endmodule

// File: tb/sim_sectored_cwf_cache.sv
module sim_sectored_cwf_cache;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int NW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, mem_cmd_valid, mem_cmd_we;
   logic [DW-1:0] rsp_rdata, mem_cmd_wdata;
   logic [AW-1:0] mem_cmd_addr;
   logic mem_cmd_ready = 1'b1;
   logic mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   logic [DW-1:0] mem [1 << AW];
   int checks = 0, fails = 0;
   int rd_count = 0, wr_count = 0, beat_gap = 0;
   logic [AW-1:0] last_rd = '0;
   logic fill_busy = 1'b0;

   always #5 clk = ~clk;

   sectored_cwf_cache u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
      .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr),
      .mem_cmd_wdata(mem_cmd_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [DW-1:0] initv(int a);
      return (32'(a) * 32'h0101_0101) ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [AW-1:0] ad(int t, int i, int s, int w);
      return AW'(t * 128 + i * 16 + s * 4 + w);
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // memory model: one-word writes, wrapped subblock reads
   initial begin
      for (int a = 0; a < (1 << AW); a++) mem[a] = initv(a);
      forever begin
         @(negedge clk);
         if (rst_n && mem_cmd_valid) begin
            if (mem_cmd_we) begin
               mem[mem_cmd_addr] = mem_cmd_wdata;
               wr_count++;
            end else begin
               int base, crit;
               rd_count++;
               last_rd = mem_cmd_addr;
               crit = int'(mem_cmd_addr) % NW;
               base = int'(mem_cmd_addr) - crit;
               fill_busy = 1'b1;
               repeat (2) @(negedge clk);
               for (int k = 0; k < NW; k++) begin
                  mem_rvalid = 1'b1;
                  mem_rdata  = mem[base + (crit + k) % NW];
                  @(negedge clk);
                  mem_rvalid = 1'b0;
                  if (k < NW - 1) repeat (beat_gap) @(negedge clk);
               end
               fill_busy = 1'b0;
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output int stall, output int lat,
                         output logic busy_at_rsp, output logic rdy_after);
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      stall = 0;
      #1;
      while (!req_ready && stall < 500) begin
         stall++;
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      lat = 0;
      rdy_after = 1'b1;
      do begin
         @(negedge clk);
         #2;
         if (lat == 0) rdy_after = req_ready;
         lat++;
      end while (!rsp_valid && lat < 500);
      rd = rsp_rdata;
      busy_at_rsp = fill_busy;
   endtask

   task automatic wait_idle();
      while (fill_busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   logic [DW-1:0] rd;
   int st_c, lt, rc0, wc0;
   logic bz, ra;

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 req_ready after reset", DW'(req_ready), 1);
      chk("R10 no mem command after reset", DW'(mem_cmd_valid), 0);
      chk("R10 no response after reset", DW'(rsp_valid), 0);
   endtask

   task automatic t_read_miss();
      beat_gap = 2;
      access(1'b0, ad(1, 2, 2, 2), '0, rd, st_c, lt, bz, ra);
      chk("R4 critical word data", rd, initv(ad(1, 2, 2, 2)));
      chk("R4 answered before fill ends", DW'(bz), 1);
      chk("R2 one read command", DW'(rd_count), 1);
      chk("R2 read command at requested word", DW'(last_rd), DW'(ad(1, 2, 2, 2)));
      chk("R8 not ready while miss pending", DW'(ra), 0);
      wait_idle();
   endtask

   task automatic t_hits();
      for (int w = 0; w < NW; w++) begin
         access(1'b0, ad(1, 2, 2, w), '0, rd, st_c, lt, bz, ra);
         chk("R3 wrapped refill word placement", rd, initv(ad(1, 2, 2, w)));
         chk("R1 hit latency one cycle", DW'(lt), 1);
      end
      chk("R1 hits cause no memory read", DW'(rd_count), 1);
   endtask

   task automatic t_write_hit();
      access(1'b1, ad(1, 2, 2, 1), 32'h1234_5678, rd, st_c, lt, bz, ra);
      access(1'b0, ad(1, 2, 2, 1), '0, rd, st_c, lt, bz, ra);
      chk("R5 write hit read back", rd, 32'h1234_5678);
      chk("R5 write hit no memory write", DW'(wr_count), 0);
      chk("R5 write hit no memory read", DW'(rd_count), 1);
   endtask

   task automatic t_stall();
      beat_gap = 3;
      access(1'b0, ad(1, 2, 0, 1), '0, rd, st_c, lt, bz, ra);
      chk("R7 miss data", rd, initv(ad(1, 2, 0, 1)));
      access(1'b0, ad(1, 2, 0, 1), '0, rd, st_c, lt, bz, ra);
      chk("R7 arrived word accepted at once", DW'(st_c), 0);
      chk("R7 arrived word data", rd, initv(ad(1, 2, 0, 1)));
      access(1'b0, ad(1, 2, 0, 3), '0, rd, st_c, lt, bz, ra);
      chk("R7 missing word stalls", DW'(st_c > 0), 1);
      chk("R7 stalled word data", rd, initv(ad(1, 2, 0, 3)));
      chk("R7 no extra read", DW'(rd_count), 2);
      wait_idle();
   endtask

   task automatic t_write_miss();
      beat_gap = 0;
      access(1'b1, ad(1, 2, 3, 0), 32'hCAFE_F00D, rd, st_c, lt, bz, ra);
      chk("R9 write miss fetches subblock", DW'(rd_count), 3);
      wait_idle();
      access(1'b0, ad(1, 2, 3, 0), '0, rd, st_c, lt, bz, ra);
      chk("R9 merged write data", rd, 32'hCAFE_F00D);
      access(1'b0, ad(1, 2, 3, 2), '0, rd, st_c, lt, bz, ra);
      chk("R9 neighbour word from memory", rd, initv(ad(1, 2, 3, 2)));
   endtask

   task automatic t_overlap();
      beat_gap = 0;
      access(1'b0, ad(1, 2, 1, 3), '0, rd, st_c, lt, bz, ra);
      chk("R4 overlap critical data", rd, initv(ad(1, 2, 1, 3)));
      access(1'b0, ad(1, 2, 2, 1), '0, rd, st_c, lt, bz, ra);
      chk("R7 hit other subblock during fill", rd, 32'h1234_5678);
      wait_idle();
      for (int w = 0; w < NW; w++) begin
         access(1'b0, ad(1, 2, 1, w), '0, rd, st_c, lt, bz, ra);
         chk("R3 fill intact after overlap", rd, initv(ad(1, 2, 1, w)));
      end
   endtask

   task automatic t_evict();
      rc0 = rd_count; wc0 = wr_count;
      access(1'b0, ad(3, 2, 0, 0), '0, rd, st_c, lt, bz, ra);
      chk("R6 new line data", rd, initv(ad(3, 2, 0, 0)));
      chk("R6 only dirty subblocks written", DW'(wr_count - wc0), 2 * NW);
      chk("R6 written word reached memory", mem[ad(1, 2, 2, 1)], 32'h1234_5678);
      chk("R6 write-miss word reached memory", mem[ad(1, 2, 3, 0)], 32'hCAFE_F00D);
      chk("R6 clean word unchanged", mem[ad(1, 2, 2, 0)], initv(ad(1, 2, 2, 0)));
      wait_idle();
      rc0 = rd_count;
      access(1'b0, ad(3, 2, 1, 0), '0, rd, st_c, lt, bz, ra);
      chk("R6 other subblock invalid after install", DW'(rd_count - rc0), 1);
      wait_idle();
      wc0 = wr_count;
      access(1'b0, ad(1, 2, 2, 1), '0, rd, st_c, lt, bz, ra);
      chk("R6 old data refetched", rd, 32'h1234_5678);
      chk("R6 clean line not written back", DW'(wr_count - wc0), 0);
      wait_idle();
   endtask

   initial begin
      t_reset();
      t_read_miss();
      t_hits();
      t_write_hit();
      t_stall();
      t_write_miss();
      t_overlap();
      t_evict();
      summary();
      $finish;
   end
endmodule